// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block turns a fast bus clock into the raster timing a TFT panel needs. A programmable divider makes a pixel period of `2*(clk_div+1)` bus cycles. Two phase machines, one per axis, walk each line and each frame through sync, back porch, active and front porch. The generator drives horizontal and vertical sync, a data-enable, a pixel clock with a one-cycle pixel strobe, and a line-end marker. It also reports the phase each axis is in and a line counter that runs down.

All timing fields are static inputs. The block copies them into a shadow set while video is off and again at every frame boundary, so a change made mid-frame takes effect only at the start of the next frame. With video off, every counter is held idle and every output sits at its inactive level.

Top module: `tft_timing_gen`

## Requirements
- R1: One pixel period lasts `2*(clk_div+1)` bus cycles. `pix_stb` is high for exactly the last bus cycle of each period. The pixel clock level is high for the first `clk_div+1` cycles of the period and low for the rest.
- R2: Each line is sync for `hsync_w+1` pixels, then back porch for `hback+1`, then active for `hact+1`, then front porch for `hfront+1`, and then the sequence repeats.
- R3: Each frame is sync for `vsync_w+1` lines, then back porch for `vback+1`, then active for `vact+1`, then front porch for `vfront+1`. The vertical phase moves only at the end of a line.
- R4: `h_state` and `v_state` report the current phase as a code: 2'b00 sync, 2'b01 back porch, 2'b10 active, 2'b11 front porch.
- R5: `line_cnt` reads `vact` during vertical sync and back porch. On active line k (k counted from 0) it reads `vact-k`. It reads 0 during vertical front porch.
- R6: Data-enable is active only while both axes are in their active phase.
- R7: When its invert input is 1, each of `hsync`, `vsync`, `den` and `lend` outputs the complement of its active-high form. `pclk_inv=1` complements the pixel clock so that data is valid on the other edge.
- R8: When `lend_en` is 1, `lend` is active during the last pixel period of every line (the final front-porch pixel). When `lend_en` is 0, `lend` stays inactive.
- R9: While `video_en` is 0, `pix_stb` is 0, sync, data-enable and line-end are at their inactive levels, and the pixel clock is at its idle level (low before inversion). From the first clock edge with `video_en` at 0, both phases are sync, and the next enable starts from the first sync pixel.
- R10: Timing, polarity and enable fields are sampled while video is off and at each frame boundary only. A change during a frame leaves that frame's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| video_en | input | 1 | Runs the timing when 1; holds it idle when 0 |
| clk_div | input | 10 | Pixel divider; the period is 2*(clk_div+1) cycles; legal minimum 1 |
| hsync_w | input | 8 | Horizontal sync width minus one |
| hback | input | 7 | Horizontal back porch minus one |
| hact | input | 11 | Active pixels per line minus one |
| hfront | input | 8 | Horizontal front porch minus one |
| vsync_w | input | 6 | Vertical sync lines minus one |
| vback | input | 8 | Vertical back porch lines minus one |
| vact | input | 10 | Active lines minus one |
| vfront | input | 8 | Vertical front porch lines minus one |
| inv_hsync | input | 1 | Inverts hsync |
| inv_vsync | input | 1 | Inverts vsync |
| inv_den | input | 1 | Inverts den |
| inv_lend | input | 1 | Inverts lend |
| pclk_inv | input | 1 | Selects the opposite pixel clock edge for valid data |
| lend_en | input | 1 | Enables the line-end output |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| pclk | output | 1 | Pixel clock level |
| pix_stb | output | 1 | One-cycle strobe at the end of each pixel period |
| lend | output | 1 | Line-end marker |
| h_state | output | 2 | Horizontal phase code |
| v_state | output | 2 | Vertical phase code |
| line_cnt | output | 10 | Down-counting line counter |

## Verification
The bench builds the block with its default field widths, so every port is full size. It programs small field values so that a whole frame lasts a few hundred bus cycles. This lets it run several complete frames per setting: the minimum divider of 1, zero-valued porches and sync widths that give one-unit phases, and a single active line. It also covers all inversions at once, a configuration change in the middle of a frame, and a disable in the middle of a frame. The reference model derives every expected output from the bus-cycle position inside the current frame.

// File: rtl/tftg_pkg.sv
package tftg_pkg;

    localparam int DIV_W  = 10;
    localparam int HSW_W  = 8;
    localparam int HBP_W  = 7;
    localparam int HACT_W = 11;
    localparam int HFP_W  = 8;
    localparam int VSW_W  = 6;
    localparam int VBP_W  = 8;
    localparam int VACT_W = 10;
    localparam int VFP_W  = 8;

    // axis counter widths: widest field on each axis
    localparam int HAX_W = HACT_W;
    localparam int VAX_W = VACT_W;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'b00,
        PH_BACK  = 2'b01,
        PH_ACT   = 2'b10,
        PH_FRONT = 2'b11
    } phase_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [HSW_W-1:0]  hsw;
        logic [HBP_W-1:0]  hbp;
        logic [HACT_W-1:0] hact;
        logic [HFP_W-1:0]  hfp;
        logic [VSW_W-1:0]  vsw;
        logic [VBP_W-1:0]  vbp;
        logic [VACT_W-1:0] vact;
        logic [VFP_W-1:0]  vfp;
        logic              inv_hs;
        logic              inv_vs;
        logic              inv_den;
        logic              inv_lend;
        logic              pclk_inv;
        logic              lend_en;
    } tim_cfg_t;

    function automatic phase_e next_phase(phase_e p);
        return phase_e'(2'(p) + 2'd1);
    endfunction

endpackage

// File: rtl/tftg_clkdiv.sv
module tftg_clkdiv #(
    parameter int W = tftg_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         stb,
    output logic         pclk_lvl
);
    localparam int CW = W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // period is 2*(div+1) cycles, so the terminal count is 2*div+1
    assign last = {div, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == last) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign stb      = run && (cnt == last);
    assign pclk_lvl = run && (cnt <= {1'b0, div});

    AST_STB_SPACED: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);                                      // R1
    AST_LVL_HIGH_AT_START: assert property (@(posedge clk) disable iff (rst)
        (run && stb) |=> (!run || pclk_lvl));               // R1

endmodule

// File: rtl/tftg_axis.sv
module tftg_axis
    import tftg_pkg::*;
#(
    parameter int CW = HAX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] lim_sync,
    input  logic [CW-1:0] lim_back,
    input  logic [CW-1:0] lim_act,
    input  logic [CW-1:0] lim_front,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          last
);
    logic [CW-1:0] cur_lim;

    always_comb begin
        unique case (phase)
            PH_SYNC:  cur_lim = lim_sync;
            PH_BACK:  cur_lim = lim_back;
            PH_ACT:   cur_lim = lim_act;
            default:  cur_lim = lim_front;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (cnt == cur_lim) begin
                cnt   <= '0;
                phase <= next_phase(phase);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign last = (phase == PH_FRONT) && (cnt == lim_front);

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && phase != $past(phase))
            |-> (phase == next_phase($past(phase))));       // R2
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= cur_lim);                                    // R2
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !step) |=> (!$past(run) || $stable(cnt)));  // R2

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
    import tftg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              video_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [HSW_W-1:0]  hsync_w,
    input  logic [HBP_W-1:0]  hback,
    input  logic [HACT_W-1:0] hact,
    input  logic [HFP_W-1:0]  hfront,
    input  logic [VSW_W-1:0]  vsync_w,
    input  logic [VBP_W-1:0]  vback,
    input  logic [VACT_W-1:0] vact,
    input  logic [VFP_W-1:0]  vfront,
    input  logic              inv_hsync,
    input  logic              inv_vsync,
    input  logic              inv_den,
    input  logic              inv_lend,
    input  logic              pclk_inv,
    input  logic              lend_en,
    output logic              hsync,
    output logic              vsync,
    output logic              den,
    output logic              pclk,
    output logic              pix_stb,
    output logic              lend,
    output logic [1:0]        h_state,
    output logic [1:0]        v_state,
    output logic [VACT_W-1:0] line_cnt
);
    tim_cfg_t cfg_in, cfg_q;

    phase_e           h_phase, v_phase;
    logic [HAX_W-1:0] h_cnt;
    logic [VAX_W-1:0] v_cnt;
    logic             h_last, v_last;
    logic             stb, pclk_lvl;
    logic             line_step, frame_wrap;

    always_comb begin
        cfg_in.div      = clk_div;
        cfg_in.hsw      = hsync_w;
        cfg_in.hbp      = hback;
        cfg_in.hact     = hact;
        cfg_in.hfp      = hfront;
        cfg_in.vsw      = vsync_w;
        cfg_in.vbp      = vback;
        cfg_in.vact     = vact;
        cfg_in.vfp      = vfront;
        cfg_in.inv_hs   = inv_hsync;
        cfg_in.inv_vs   = inv_vsync;
        cfg_in.inv_den  = inv_den;
        cfg_in.inv_lend = inv_lend;
        cfg_in.pclk_inv = pclk_inv;
        cfg_in.lend_en  = lend_en;
    end

    // shadow copy refreshed only while idle or at a frame boundary
    always_ff @(posedge clk) begin
        if (rst || !video_en || frame_wrap) cfg_q <= cfg_in;
    end

    tftg_clkdiv #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (video_en),
        .div      (cfg_q.div),
        .stb      (stb),
        .pclk_lvl (pclk_lvl)
    );

    tftg_axis #(.CW(HAX_W)) u_hax (
        .clk       (clk),
        .rst       (rst),
        .run       (video_en),
        .step      (stb),
        .lim_sync  (HAX_W'(cfg_q.hsw)),
        .lim_back  (HAX_W'(cfg_q.hbp)),
        .lim_act   (HAX_W'(cfg_q.hact)),
        .lim_front (HAX_W'(cfg_q.hfp)),
        .phase     (h_phase),
        .cnt       (h_cnt),
        .last      (h_last)
    );

    assign line_step  = stb && h_last;
    assign frame_wrap = line_step && v_last;

    tftg_axis #(.CW(VAX_W)) u_vax (
        .clk       (clk),
        .rst       (rst),
        .run       (video_en),
        .step      (line_step),
        .lim_sync  (VAX_W'(cfg_q.vsw)),
        .lim_back  (VAX_W'(cfg_q.vbp)),
        .lim_act   (VAX_W'(cfg_q.vact)),
        .lim_front (VAX_W'(cfg_q.vfp)),
        .phase     (v_phase),
        .cnt       (v_cnt),
        .last      (v_last)
    );

    always_comb begin
        unique case (v_phase)
            PH_ACT:   line_cnt = cfg_q.vact - v_cnt;
            PH_FRONT: line_cnt = '0;
            default:  line_cnt = cfg_q.vact;
        endcase
    end

    assign h_state = h_phase;
    assign v_state = v_phase;
    assign pix_stb = stb;
    assign pclk    = pclk_lvl ^ cfg_q.pclk_inv;
    assign hsync   = (video_en && h_phase == PH_SYNC) ^ cfg_q.inv_hs;
    assign vsync   = (video_en && v_phase == PH_SYNC) ^ cfg_q.inv_vs;
    assign den     = (video_en && h_phase == PH_ACT && v_phase == PH_ACT) ^ cfg_q.inv_den;
    assign lend    = (video_en && cfg_q.lend_en && h_last) ^ cfg_q.inv_lend;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (video_en && !frame_wrap) |=> $stable(cfg_q));          // R10
    AST_V_MOVES_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
        (video_en && !line_step) |=> $stable(v_phase));         // R3
    AST_LINE_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        line_cnt <= cfg_q.vact);                                // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !video_en |=> (h_phase == PH_SYNC && v_phase == PH_SYNC && h_cnt == '0));  // R9

endmodule

// File: tb/tb_tft_timing_gen.sv
module tb_tft_timing_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic video_en = 1'b0;
    logic [9:0]  clk_div = '0;
    logic [7:0]  hsync_w = '0;
    logic [6:0]  hback = '0;
    logic [10:0] hact = '0;
    logic [7:0]  hfront = '0;
    logic [5:0]  vsync_w = '0;
    logic [7:0]  vback = '0;
    logic [9:0]  vact = '0;
    logic [7:0]  vfront = '0;
    logic inv_hsync = 0, inv_vsync = 0, inv_den = 0, inv_lend = 0, pclk_inv = 0, lend_en = 0;
    logic hsync, vsync, den, pclk, pix_stb, lend;
    logic [1:0] h_state, v_state;
    logic [9:0] line_cnt;

    always #5 clk = ~clk;

    tft_timing_gen dut (
        .clk(clk), .rst(rst), .video_en(video_en), .clk_div(clk_div),
        .hsync_w(hsync_w), .hback(hback), .hact(hact), .hfront(hfront),
        .vsync_w(vsync_w), .vback(vback), .vact(vact), .vfront(vfront),
        .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_den(inv_den),
        .inv_lend(inv_lend), .pclk_inv(pclk_inv), .lend_en(lend_en),
        .hsync(hsync), .vsync(vsync), .den(den), .pclk(pclk), .pix_stb(pix_stb),
        .lend(lend), .h_state(h_state), .v_state(v_state), .line_cnt(line_cnt)
    );

    int total = 0;
    int fails = 0;
    string focus = "";
    bit started = 0;
    bit done = 0;

    // model state: latched configuration and bus-cycle position inside the frame
    int c = 0;
    int md, mhs, mhb, mha, mhf, mvs, mvb, mva, mvf;
    bit mih, miv, mid, mil, mpe, mle;

    function automatic int flen();
        return 2 * (md + 1) * (mhs + mhb + mha + mhf + 4) * (mvs + mvb + mva + mvf + 4);
    endfunction

    task automatic latch();
        md = clk_div; mhs = hsync_w; mhb = hback; mha = hact; mhf = hfront;
        mvs = vsync_w; mvb = vback; mva = vact; mvf = vfront;
        mih = inv_hsync; miv = inv_vsync; mid = inv_den; mil = inv_lend;
        mpe = pclk_inv; mle = lend_en;
    endtask

    function automatic int ph(int pos, int a, int b, int d);
        if (pos < a + 1) return 0;
        if (pos < a + b + 2) return 1;
        if (pos < a + b + d + 3) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst || !video_en) begin
            c = 0;
            latch();
        end else begin
            c = c + 1;
            if (c == flen()) begin
                c = 0;
                latch();
            end
        end
    end

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s%s %s: actual %0d expected %0d at %0t", tag, focus, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst && !done) begin
            int per, p, sub, htot, x, y, hp, vp, ln;
            bit en;
            en   = video_en;
            per  = 2 * (md + 1);
            p    = c / per;
            sub  = c % per;
            htot = mhs + mhb + mha + mhf + 4;
            x    = p % htot;
            y    = p / htot;
            hp   = ph(x, mhs, mhb, mha);
            vp   = ph(y, mvs, mvb, mva);
            if (vp == 2)      ln = mva - (y - (mvs + mvb + 2));
            else if (vp == 3) ln = 0;
            else              ln = mva;
            chk("R1", "pix_stb", pix_stb, int'(en && sub == per - 1));
            chk("R1", "pclk", pclk, int'((en && sub <= md) ^ mpe));
            chk("R2", "hsync", hsync, int'((en && hp == 0) ^ mih));
            chk("R3", "vsync", vsync, int'((en && vp == 0) ^ miv));
            chk("R4", "h_state", h_state, hp);
            chk("R4", "v_state", v_state, vp);
            chk("R5", "line_cnt", line_cnt, ln);
            chk("R6", "den", den, int'((en && hp == 2 && vp == 2) ^ mid));
            chk("R8", "lend", lend, int'((en && mle && x == htot - 1) ^ mil));
        end
    end

    task automatic cfg_a();
        clk_div = 10'd1; hsync_w = 8'd1; hback = 7'd0; hact = 11'd3; hfront = 8'd1;
        vsync_w = 6'd0; vback = 8'd1; vact = 10'd2; vfront = 8'd0;
        inv_hsync = 0; inv_vsync = 0; inv_den = 0; inv_lend = 0; pclk_inv = 0; lend_en = 1;
    endtask

    // all inversions on (R7), line-end disabled, single active line
    task automatic cfg_b();
        clk_div = 10'd2; hsync_w = 8'd0; hback = 7'd2; hact = 11'd1; hfront = 8'd0;
        vsync_w = 6'd1; vback = 8'd0; vact = 10'd0; vfront = 8'd2;
        inv_hsync = 1; inv_vsync = 1; inv_den = 1; inv_lend = 1; pclk_inv = 1; lend_en = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        cfg_a();
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // reset state, video off (R9)
        chk("R9", "reset pix_stb", pix_stb, 0);
        chk("R9", "reset hsync", hsync, 0);
        chk("R9", "reset den", den, 0);
        chk("R9", "reset h_state", h_state, 0);
        @(posedge clk); #1;
        video_en = 1'b1;
        cycles(800);
        // inverted polarities and other edge (R7)
        focus = " R7";
        video_en = 1'b0;
        cycles(3);
        cfg_b();
        video_en = 1'b1;
        cycles(700);
        video_en = 1'b0;
        cycles(2);
        @(negedge clk);
        chk("R7", "idle inverted hsync", hsync, 1);
        chk("R7", "idle inverted pclk", pclk, 1);
        // mid-frame configuration change (R10)
        @(posedge clk); #1;
        focus = " R10";
        cfg_a();
        video_en = 1'b1;
        cycles(100);
        cfg_b();
        cycles(600);
        // disable in mid-frame then restart (R9)
        focus = " R9";
        video_en = 1'b0;
        cycles(20);
        video_en = 1'b1;
        cycles(400);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule